// File: doc/BRIEF.md
# Vector Load/Store Sequencer with Data-Dependent Early Exit

This block walks through the elements of a 64-bit vector load or store, one memory access per element, strictly in ascending element order. For element i it reads a base register at index (base + i), adds a signed-agnostic immediate to form the effective address, and then either fetches a doubleword into register (dest + i) or sends register (dest + i) out to memory. Each tested value is classified into a small condition field that is written out for element i.

A single configured test bit is compared against the zero flag of every element's condition field. On a match the operation stops early and reports a shortened vector length. An inclusive flag decides whether the failing element counts toward that length. For stores in non-inclusive mode, the failing element is never written to memory. Because a loaded value reaches the register file before the next element's base register is read, a destination range offset by one from the base range lets the block walk a chain of pointers.

Top module: `vls_ffirst_seq`

## Requirements
- R1: For element i the memory address is the register at index (base + i) modulo the register count, plus the immediate. Requests go out in ascending element order, with at most one outstanding. Address, write flag and write data stay stable from the cycle the request rises until the cycle of `mem_ack`.
- R2: On a load, `rf_we` pulses in the `mem_ack` cycle with `rf_wr_idx` = (dest + i) and `rf_wr_data` = `mem_rdata`.
- R3: Every processed element produces one `cr_we` pulse with `cr_idx` = i. `cr_val` is 4'b0001 for a zero value, 4'b0010 when bit 63 is set, and 4'b0100 otherwise. A load writes it in the `mem_ack` cycle. A store writes it before its memory request.
- R4: An element fails when `cr_val[0]` equals `cfg_test_bit`.
- R5: When element i fails, `final_vl` becomes i+1 if `cfg_inclusive` is 1, and i if it is 0.
- R6: After a failing element there is no further memory request, register write or condition write. `done` is a single-cycle pulse and the block returns to idle.
- R7: On a store with `cfg_inclusive` = 0, a failing element issues no memory request.
- R8: On a store with `cfg_inclusive` = 1, a failing element is still written to memory, and `done` follows its acknowledgement.
- R9: A load result written for element i is the base register value used by element i+1 when dest = base + 1.
- R10: If no element fails, `final_vl` equals `cfg_vl` and `done` pulses after element `cfg_vl`-1 completes.
- R11: A start with `cfg_vl` = 0 pulses `done` on the next cycle with `final_vl` = 0, no memory request and no condition write.
- R12: After reset, `busy`, `done`, `mem_req`, `rf_we` and `cr_we` are 0 and `final_vl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| cfg_vl | input | VL_W | Requested vector length |
| cfg_base_idx | input | RIDX_W | First base register index |
| cfg_dst_idx | input | RIDX_W | First destination (load) or source (store) register index |
| cfg_imm | input | DATA_W | Immediate added to each base value |
| cfg_store | input | 1 | 1 = store, 0 = load |
| cfg_test_bit | input | 1 | Value of the zero flag that ends the loop |
| cfg_inclusive | input | 1 | 1 = failing element counted in the final length |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | DATA_W | Effective address |
| mem_wdata | output | DATA_W | Store data |
| mem_ack | input | 1 | Request accepted / load data valid |
| mem_rdata | input | DATA_W | Load data, valid with `mem_ack` |
| rf_ra_idx | output | RIDX_W | Base register read index |
| rf_ra_data | input | DATA_W | Base register value (combinational read) |
| rf_rb_idx | output | RIDX_W | Store source register read index |
| rf_rb_data | input | DATA_W | Store source value (combinational read) |
| rf_we | output | 1 | Register write strobe |
| rf_wr_idx | output | RIDX_W | Register write index |
| rf_wr_data | output | DATA_W | Register write data |
| cr_we | output | 1 | Condition field write strobe |
| cr_idx | output | VL_W | Element index of the condition field |
| cr_val | output | 4 | Condition field value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| final_vl | output | VL_W | Resulting vector length, held until the next start |

## Verification
Most internal faults reach the ports within one element. A wrong element counter or wrong index arithmetic shows up as a wrong `mem_addr` or `rf_wr_idx` on the next request. A lost failure flag shows up either as an extra memory request right after the failing element or as a missing store. A wrong truncation choice shows up as a `final_vl` that is off by one on the `done` pulse. The reference model predicts every memory transaction, register write and condition write in order, and compares each of them in the cycle it occurs. Any stray event after the predicted stream has run out is flagged at once.

// File: rtl/vls_seq_pkg.sv
// Package: shared state encoding and condition-field bit positions for the
// vector load/store early-exit sequencer. Assumes a 4-bit condition field.
package vls_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam int COND_W   = 4;
    localparam int COND_ZERO = 0;
    localparam int COND_NEG  = 1;
    localparam int COND_POS  = 2;

endpackage

// File: rtl/vls_ea_gen.sv
// Module: per-element register index and effective-address generation.
// Forms base and destination register indices by adding the element number
// (modulo the register count) and adds the immediate to the base value.
// Assumes VL_W <= RIDX_W so the element number fits the index width.
module vls_ea_gen #(
    parameter int RIDX_W = 7,
    parameter int VL_W   = 6,
    parameter int DATA_W = 64
) (
    input  logic [RIDX_W-1:0] base_idx,
    input  logic [RIDX_W-1:0] dst_idx,
    input  logic [VL_W-1:0]   elem_idx,
    input  logic [DATA_W-1:0] imm,
    input  logic [DATA_W-1:0] base_val,
    output logic [RIDX_W-1:0] base_rd_idx,
    output logic [RIDX_W-1:0] dst_el_idx,
    output logic [DATA_W-1:0] eff_addr
);

    logic [RIDX_W-1:0] elem_ext;

    // Widen the element number to the register index width.
    always_comb elem_ext = RIDX_W'(elem_idx);

    // Index sums wrap around the register file; address is base value + imm.
    always_comb begin
        base_rd_idx = base_idx + elem_ext;
        dst_el_idx  = dst_idx + elem_ext;
        eff_addr    = base_val + imm;
    end

endmodule

// File: rtl/vls_cond_eval.sv
// Module: classifies a 64-bit value into a one-hot condition field
// (zero / negative / positive) and flags a match of the zero flag against
// the configured test bit. Purely combinational.
module vls_cond_eval
    import vls_seq_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] value,
    input  logic              test_bit,
    output logic [COND_W-1:0] cond,
    output logic              hit
);

    logic is_zero;
    logic is_neg;

    // Derive the sign and zero properties of the tested value.
    always_comb begin
        is_zero = (value == '0);
        is_neg  = value[DATA_W-1];
    end

    // Build the one-hot field and compare its zero flag with the test bit.
    always_comb begin
        cond            = '0;
        cond[COND_ZERO] = is_zero;
        cond[COND_NEG]  = is_neg;
        cond[COND_POS]  = !is_zero && !is_neg;
        hit             = (cond[COND_ZERO] == test_bit);
    end

endmodule

// File: rtl/vls_seq_ctrl.sv
// Module: element sequencer. Latches the configuration on start and steps one
// element at a time through issue and wait phases, with a single memory
// request outstanding. Decides early exit from the classification result and
// produces the final length and the done pulse.
// Assumes memory holds mem_ack for one cycle per request, and that the
// register file reads combinationally and writes on the clock edge.
module vls_seq_ctrl
    import vls_seq_pkg::*;
#(
    parameter int RIDX_W = 7,
    parameter int VL_W   = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   cfg_vl,
    input  logic [RIDX_W-1:0] cfg_base_idx,
    input  logic [RIDX_W-1:0] cfg_dst_idx,
    input  logic [DATA_W-1:0] cfg_imm,
    input  logic              cfg_store,
    input  logic              cfg_test_bit,
    input  logic              cfg_inclusive,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] eff_addr,
    input  logic [DATA_W-1:0] store_data,
    input  logic [COND_W-1:0] cond,
    input  logic              hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rf_we,
    output logic              cr_we,
    output logic              busy,
    output logic              done,
    output logic [VL_W-1:0]   final_vl,
    output logic [VL_W-1:0]   elem_idx,
    output logic [RIDX_W-1:0] base_q,
    output logic [RIDX_W-1:0] dst_q,
    output logic [DATA_W-1:0] imm_q,
    output logic              test_q,
    output logic              store_q
);

    seq_state_e        state;
    logic [VL_W-1:0]   vl_q;
    logic [VL_W-1:0]   idx_nxt;
    logic              incl_q;
    logic              fail_q;
    logic              elem_fail;
    logic              done_q;
    logic [VL_W-1:0]   final_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Next element number and the failure verdict used when the access ends.
    always_comb begin
        idx_nxt   = elem_idx + VL_W'(1);
        elem_fail = store_q ? fail_q : hit;
    end

    // Main sequencing: latch config, issue, wait, decide exit or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            elem_idx <= '0;
            vl_q     <= '0;
            base_q   <= '0;
            dst_q    <= '0;
            imm_q    <= '0;
            test_q   <= 1'b0;
            store_q  <= 1'b0;
            incl_q   <= 1'b0;
            fail_q   <= 1'b0;
            done_q   <= 1'b0;
            final_q  <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        vl_q     <= cfg_vl;
                        base_q   <= cfg_base_idx;
                        dst_q    <= cfg_dst_idx;
                        imm_q    <= cfg_imm;
                        test_q   <= cfg_test_bit;
                        store_q  <= cfg_store;
                        incl_q   <= cfg_inclusive;
                        elem_idx <= '0;
                        fail_q   <= 1'b0;
                        if (cfg_vl == '0) begin
                            done_q  <= 1'b1;
                            final_q <= '0;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    addr_q  <= eff_addr;
                    wdata_q <= store_data;
                    if (store_q) begin
                        fail_q <= hit;
                        if (hit && !incl_q) begin
                            state   <= ST_IDLE;
                            done_q  <= 1'b1;
                            final_q <= elem_idx;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_ack) begin
                        if (elem_fail) begin
                            state   <= ST_IDLE;
                            done_q  <= 1'b1;
                            final_q <= incl_q ? idx_nxt : elem_idx;
                        end else if (idx_nxt == vl_q) begin
                            state   <= ST_IDLE;
                            done_q  <= 1'b1;
                            final_q <= vl_q;
                        end else begin
                            elem_idx <= idx_nxt;
                            state    <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory, register-write and condition-write strobes.
    always_comb begin
        mem_req   = (state == ST_WAIT);
        mem_we    = store_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        rf_we     = (state == ST_WAIT) && !store_q && mem_ack;
        cr_we     = ((state == ST_ISSUE) && store_q) || rf_we;
        busy      = (state != ST_IDLE);
        done      = done_q;
        final_vl  = final_q;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R1
    AST_COND_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($countones(cond) == 1)); // R3
    AST_FINAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (final_vl <= vl_q)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we && !cr_we)); // R6
    AST_SUPPRESS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ISSUE) && store_q && hit && !incl_q) |=> (!mem_req && done)); // R7
    AST_INCL_STORE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ISSUE) && store_q && hit && incl_q) |=> (mem_req && mem_we)); // R8
    AST_ZERO_VL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (cfg_vl == '0)) |=> (done && !busy && (final_vl == '0))); // R11

endmodule

// File: rtl/vls_ffirst_seq.sv
// Module: top of the vector load/store sequencer with data-dependent early
// exit. Wires the address generator, the value classifier and the element
// sequencer to the memory, register-file and condition-field ports.
// Assumes a combinational register-file read and 64-bit elements only.
module vls_ffirst_seq
    import vls_seq_pkg::*;
#(
    parameter int RIDX_W = 7,
    parameter int VL_W   = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   cfg_vl,
    input  logic [RIDX_W-1:0] cfg_base_idx,
    input  logic [RIDX_W-1:0] cfg_dst_idx,
    input  logic [DATA_W-1:0] cfg_imm,
    input  logic              cfg_store,
    input  logic              cfg_test_bit,
    input  logic              cfg_inclusive,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [RIDX_W-1:0] rf_ra_idx,
    input  logic [DATA_W-1:0] rf_ra_data,
    output logic [RIDX_W-1:0] rf_rb_idx,
    input  logic [DATA_W-1:0] rf_rb_data,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              cr_we,
    output logic [VL_W-1:0]   cr_idx,
    output logic [COND_W-1:0] cr_val,
    output logic              busy,
    output logic              done,
    output logic [VL_W-1:0]   final_vl
);

    logic [VL_W-1:0]   elem_idx;
    logic [RIDX_W-1:0] base_q;
    logic [RIDX_W-1:0] dst_q;
    logic [DATA_W-1:0] imm_q;
    logic              test_q;
    logic              store_q;
    logic [RIDX_W-1:0] dst_el_idx;
    logic [DATA_W-1:0] eff_addr;
    logic [DATA_W-1:0] tested_val;
    logic [COND_W-1:0] cond;
    logic              hit;

    vls_ea_gen #(
        .RIDX_W(RIDX_W),
        .VL_W  (VL_W),
        .DATA_W(DATA_W)
    ) u_ea (
        .base_idx   (base_q),
        .dst_idx    (dst_q),
        .elem_idx   (elem_idx),
        .imm        (imm_q),
        .base_val   (rf_ra_data),
        .base_rd_idx(rf_ra_idx),
        .dst_el_idx (dst_el_idx),
        .eff_addr   (eff_addr)
    );

    // Stores test the outgoing register value, loads test the returned data.
    always_comb tested_val = store_q ? rf_rb_data : mem_rdata;

    vls_cond_eval #(
        .DATA_W(DATA_W)
    ) u_cond (
        .value   (tested_val),
        .test_bit(test_q),
        .cond    (cond),
        .hit     (hit)
    );

    vls_seq_ctrl #(
        .RIDX_W(RIDX_W),
        .VL_W  (VL_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_vl       (cfg_vl),
        .cfg_base_idx (cfg_base_idx),
        .cfg_dst_idx  (cfg_dst_idx),
        .cfg_imm      (cfg_imm),
        .cfg_store    (cfg_store),
        .cfg_test_bit (cfg_test_bit),
        .cfg_inclusive(cfg_inclusive),
        .mem_ack      (mem_ack),
        .eff_addr     (eff_addr),
        .store_data   (rf_rb_data),
        .cond         (cond),
        .hit          (hit),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .rf_we        (rf_we),
        .cr_we        (cr_we),
        .busy         (busy),
        .done         (done),
        .final_vl     (final_vl),
        .elem_idx     (elem_idx),
        .base_q       (base_q),
        .dst_q        (dst_q),
        .imm_q        (imm_q),
        .test_q       (test_q),
        .store_q      (store_q)
    );

    // Route the per-element indices and classification to the output ports.
    always_comb begin
        rf_rb_idx  = dst_el_idx;
        rf_wr_idx  = dst_el_idx;
        rf_wr_data = mem_rdata;
        cr_idx     = elem_idx;
        cr_val     = cond;
    end

endmodule

// File: tb/tb_vls_ffirst_seq.sv
// Bench: a behavioural reference model predicts the ordered stream of memory
// transactions, register writes and condition writes, plus the final length.
// Every observed event is compared on the clock in which it occurs.
module tb_vls_ffirst_seq;

    localparam int RIDX_W = 7;
    localparam int VL_W   = 6;
    localparam int DATA_W = 64;
    localparam int NREG   = 1 << RIDX_W;
    localparam int WD_LIMIT = 200000;

    typedef struct {
        logic [63:0] addr;
        logic        we;
        logic [63:0] data;
    } mem_ev_t;
    typedef struct {
        int          idx;
        logic [63:0] data;
    } rf_ev_t;
    typedef struct {
        int          idx;
        logic [3:0]  val;
    } cr_ev_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [VL_W-1:0]   cfg_vl = '0;
    logic [RIDX_W-1:0] cfg_base_idx = '0;
    logic [RIDX_W-1:0] cfg_dst_idx = '0;
    logic [DATA_W-1:0] cfg_imm = '0;
    logic              cfg_store = 1'b0;
    logic              cfg_test_bit = 1'b0;
    logic              cfg_inclusive = 1'b0;
    logic              mem_req, mem_we;
    logic [DATA_W-1:0] mem_addr, mem_wdata;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [RIDX_W-1:0] rf_ra_idx, rf_rb_idx, rf_wr_idx;
    logic [DATA_W-1:0] rf_ra_data, rf_rb_data, rf_wr_data;
    logic              rf_we, cr_we, busy, done;
    logic [VL_W-1:0]   cr_idx, final_vl;
    logic [3:0]        cr_val;

    logic [63:0] rf [NREG];
    logic [63:0] dmem [logic [63:0]];
    logic [63:0] ref_rf [NREG];
    logic [63:0] ref_mem [logic [63:0]];
    mem_ev_t exp_mem [$];
    rf_ev_t  exp_rf [$];
    cr_ev_t  exp_cr [$];
    int exp_final = 0;

    int n_checks = 0;
    int n_fail = 0;
    int ops_done = 0;
    int cyc = 0;
    int rst_seen = 0;
    int txn_n = 0;
    int wait_left = 0;
    bit pend = 0;

    vls_ffirst_seq #(
        .RIDX_W(RIDX_W),
        .VL_W  (VL_W),
        .DATA_W(DATA_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_vl(cfg_vl), .cfg_base_idx(cfg_base_idx), .cfg_dst_idx(cfg_dst_idx),
        .cfg_imm(cfg_imm), .cfg_store(cfg_store), .cfg_test_bit(cfg_test_bit),
        .cfg_inclusive(cfg_inclusive),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rf_ra_idx(rf_ra_idx), .rf_ra_data(rf_ra_data),
        .rf_rb_idx(rf_rb_idx), .rf_rb_data(rf_rb_data),
        .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .cr_we(cr_we), .cr_idx(cr_idx), .cr_val(cr_val),
        .busy(busy), .done(done), .final_vl(final_vl)
    );

    always #4 clk = ~clk;

    function automatic logic [63:0] reg_init(int k);
        if (k == 40) return 64'h1000;
        if (k < 32)  return 64'h2000 + 64'(k) * 64'd64;
        if (k == 50) return 64'd0;
        if (k == 51) return 64'h8000_0000_0000_0001;
        if (k < 64)  return 64'h100 + 64'(k);
        return 64'(k) * 64'd3 + 64'd1;
    endfunction

    function automatic logic [63:0] mem_init(logic [63:0] a);
        if (a >= 64'h1000 && a < 64'h1040) begin
            if (a[3]) return (a[5:4] == 2'd3) ? 64'd0 : a + 64'd8;
            return 64'hFEED;
        end
        return {~a[31:0], a[31:0]};
    endfunction

    function automatic logic [3:0] cond_of(logic [63:0] d);
        if (d == 64'd0) return 4'b0001;
        if (d[63])      return 4'b0010;
        return 4'b0100;
    endfunction

    function automatic logic [63:0] ref_read(logic [63:0] a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return mem_init(a);
    endfunction

    assign rf_ra_data = rf[rf_ra_idx];
    assign rf_rb_data = rf[rf_rb_idx];

    // Register file: initial contents on reset, DUT writes on the edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) rf[k] <= reg_init(k);
        end else if (rf_we) begin
            rf[rf_wr_idx] <= rf_wr_data;
        end
    end

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic predict(int vl, int ra, int rt, logic [63:0] imm, bit st, bit tb, bit incl);
        exp_final = vl;
        for (int i = 0; i < vl; i++) begin
            logic [63:0] ea;
            logic [63:0] d;
            logic [3:0]  c;
            bit          fl;
            ea = ref_rf[(ra + i) % NREG] + imm;
            if (!st) begin
                d = ref_read(ea);
                exp_mem.push_back('{ea, 1'b0, 64'd0});
                ref_rf[(rt + i) % NREG] = d;
                exp_rf.push_back('{(rt + i) % NREG, d});
            end else begin
                d = ref_rf[(rt + i) % NREG];
            end
            c = cond_of(d);
            exp_cr.push_back('{i, c});
            fl = (c[0] == tb);
            if (st) begin
                if (fl && !incl) begin
                    exp_final = i;
                    break;
                end
                exp_mem.push_back('{ea, 1'b1, d});
                ref_mem[ea] = d;
            end
            if (fl) begin
                exp_final = incl ? i + 1 : i;
                break;
            end
        end
    endtask

    // Memory responder and per-clock comparison against the reference model.
    always @(negedge clk) begin
        #1;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (rst_n && mem_req) begin
            if (!pend) begin
                pend = 1'b1;
                wait_left = txn_n % 3;
            end
            if (wait_left == 0) begin
                pend = 1'b0;
                txn_n++;
                mem_ack = 1'b1;
                if (mem_we) dmem[mem_addr] = mem_wdata;
                else mem_rdata = dmem.exists(mem_addr) ? dmem[mem_addr] : mem_init(mem_addr);
            end else begin
                wait_left--;
            end
        end
        #1;
        if (!rst_n) begin
            rst_seen++;
            if (rst_seen == 2) begin
                chk(done == 1'b0, "R12", "done in reset", 64'(done), 0);
                chk(busy == 1'b0, "R12", "busy in reset", 64'(busy), 0);
                chk(mem_req == 1'b0, "R12", "mem_req in reset", 64'(mem_req), 0);
                chk(rf_we == 1'b0 && cr_we == 1'b0, "R12", "write strobes in reset",
                    64'({rf_we, cr_we}), 0);
                chk(final_vl == '0, "R12", "final_vl in reset", 64'(final_vl), 0);
            end
        end else begin
            if (start)
                predict(int'(cfg_vl), int'(cfg_base_idx), int'(cfg_dst_idx), cfg_imm,
                        cfg_store, cfg_test_bit, cfg_inclusive);
            if (mem_req && mem_ack) begin
                if (exp_mem.size() == 0) begin
                    chk(0, "R6 R7", "unexpected memory access", mem_addr, 0);
                end else begin
                    mem_ev_t e;
                    e = exp_mem.pop_front();
                    chk(mem_addr == e.addr, "R1 R9", "memory address", mem_addr, e.addr);
                    chk(mem_we == e.we, "R1 R8", "memory direction", 64'(mem_we), 64'(e.we));
                    if (e.we) chk(mem_wdata == e.data, "R8", "store data", mem_wdata, e.data);
                end
            end
            if (rf_we) begin
                if (exp_rf.size() == 0) begin
                    chk(0, "R6", "unexpected register write", 64'(rf_wr_idx), 0);
                end else begin
                    rf_ev_t r;
                    r = exp_rf.pop_front();
                    chk(int'(rf_wr_idx) == r.idx, "R2", "register write index", 64'(rf_wr_idx), 64'(r.idx));
                    chk(rf_wr_data == r.data, "R2 R9", "register write data", rf_wr_data, r.data);
                end
            end
            if (cr_we) begin
                if (exp_cr.size() == 0) begin
                    chk(0, "R6 R11", "unexpected condition write", 64'(cr_idx), 0);
                end else begin
                    cr_ev_t c;
                    c = exp_cr.pop_front();
                    chk(int'(cr_idx) == c.idx, "R3", "condition index", 64'(cr_idx), 64'(c.idx));
                    chk(cr_val == c.val, "R3", "condition value", 64'(cr_val), 64'(c.val));
                end
            end
            if (done) begin
                chk(int'(final_vl) == exp_final, "R4 R5 R10 R11", "final length",
                    64'(final_vl), 64'(exp_final));
                chk(exp_mem.size() == 0 && exp_rf.size() == 0 && exp_cr.size() == 0,
                    "R6 R7", "events outstanding at done",
                    64'(exp_mem.size() + exp_rf.size() + exp_cr.size()), 0);
                chk(busy == 1'b0, "R6", "busy after done", 64'(busy), 0);
                ops_done++;
            end
        end
    end

    task automatic run_op(int vl, int ra, int rt, logic [63:0] imm, bit st, bit tb, bit incl);
        int target;
        target = ops_done + 1;
        @(negedge clk);
        #3;
        cfg_vl        = VL_W'(vl);
        cfg_base_idx  = RIDX_W'(ra);
        cfg_dst_idx   = RIDX_W'(rt);
        cfg_imm       = imm;
        cfg_store     = st;
        cfg_test_bit  = tb;
        cfg_inclusive = incl;
        start         = 1'b1;
        @(negedge clk);
        #3;
        start = 1'b0;
        while (ops_done < target) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports a summary.
    initial begin
        wait (cyc >= WD_LIMIT);
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WD_LIMIT);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks + 1, n_fail + 1);
        $finish;
    end

    initial begin
        for (int k = 0; k < NREG; k++) ref_rf[k] = reg_init(k);
        repeat (4) @(negedge clk);
        #3;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R10 R2 R3: plain load, no element fails
        run_op(5, 0, 64, 64'h10, 1'b0, 1'b1, 1'b0);
        // R4 R5: test bit 0 fails on the first nonzero element
        run_op(4, 0, 70, 64'h0, 1'b0, 1'b0, 1'b0);
        run_op(4, 0, 70, 64'h0, 1'b0, 1'b0, 1'b1);
        // R9: pointer chase with destination one above base, both modes
        run_op(8, 40, 41, 64'h8, 1'b0, 1'b1, 1'b1);
        run_op(8, 40, 41, 64'h8, 1'b0, 1'b1, 1'b0);
        // R7: failing store suppressed in non-inclusive mode
        run_op(8, 4, 46, 64'h0, 1'b1, 1'b1, 1'b0);
        // R8: failing store still written in inclusive mode
        run_op(8, 4, 46, 64'h0, 1'b1, 1'b1, 1'b1);
        // R10: store run with a negative value and no failure
        run_op(3, 8, 51, 64'h0, 1'b1, 1'b1, 1'b0);
        // R2: read back stored values
        run_op(2, 4, 80, 64'h0, 1'b0, 1'b1, 1'b0);
        // R11: zero length
        run_op(0, 0, 90, 64'h0, 1'b0, 1'b1, 1'b0);
        run_op(0, 4, 90, 64'h0, 1'b1, 1'b0, 1'b1);
        // R1 R10: longest vector, register indices wrap
        run_op(63, 100, 0, 64'h40, 1'b0, 1'b1, 1'b0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule